// File: doc/BRIEF.md
# Reset and Clock Mode Sequencer

This block sits at the root of a chip's clock and reset tree. It watches a synchronous active-low reset pin, a three-bit mode code and a pin that bypasses the PLL. From these it produces the internal core reset, a select line that picks either the PLL output or a halved reference clock, and the clock multiplication ratio. The analog PLL is represented only by a lock input. The clock multiplexer itself lives outside the block and is driven by the select output.

Two operating states exist. In run state the core is clocked from the PLL at the ratio held in the block. The default ratio is 22, in tenths of the reference frequency (2.2 times). In programming state the PLL is bypassed and a new ratio may be written. Every write starts a settle window of `SETTLE_CYC` reference cycles. The exit is held back until that window has run out. Entering or leaving programming state fires a fresh internal reset pulse. A pulse caused by leaving programming state keeps the newly written ratio. Only the external reset pin brings back the default ratio.

Top module: `clkmode_seq`

## Requirements
- R1: Mode code 3'b111 with `pll_bypass` high, seen in run state, sets `prog_mode` after that edge. Mode code 3'b000 requests the return to run state. The six other codes change nothing.
- R2: While `rst_n` is low, the outputs are `core_rst_n`=0, `prog_mode`=0, `clk_sel_pll`=1, `ref_div2`=0, `wr_open`=0, `bad_entry`=0, `early_exit`=0 and `ratio`=`RATIO_DEF` (22).
- R3: With `pll_lock` high, `core_rst_n` stays 0 for exactly `INT_RST_CYC` (8) edges after `rst_n` rises, and is 1 from the 8th edge on.
- R4: After `rst_n` rises, `ref_div2` toggles on every edge. After k edges it equals k mod 2.
- R5: `wr_open` becomes 1 after `ACCEPT_CYC` (22) edges following the release of `rst_n`, and then stays 1. Ratio writes made earlier are ignored.
- R6: A ratio write (`ratio_wr`) is taken only in programming state while `wr_open` is 1. It loads `ratio_wdata` on that edge. A write in run state leaves `ratio` unchanged.
- R7: Mode code 3'b111 with `pll_bypass` low is ignored: `prog_mode` stays 0. It sets the sticky `bad_entry` flag.
- R8: After a write on edge W, the return to run state happens at edge W+max(k, `SETTLE_CYC`+1), where edge W+k is the first edge that sees 3'b000. `early_exit` becomes and stays 1 if k is at most `SETTLE_CYC`.
- R9: Every change of `prog_mode` starts a new internal reset of `INT_RST_CYC` edges. Leaving programming state keeps the written ratio.
- R10: `clk_sel_pll` changes only on an edge where `core_rst_n` was 0 before the edge. It reads 0 from one edge after entry into programming state, and 1 from one edge after the exit.
- R11: When the core returns to the PLL clock, the internal reset is held at its last cycle while `pll_lock` is 0. It ends on the first edge after `pll_lock` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | External reset pin, synchronous, active low |
| mode_sel | input | 3 | Mode code: 000 run, 111 program, others reserved |
| pll_bypass | input | 1 | Must be high to enter programming state |
| pll_lock | input | 1 | Abstract PLL lock indication |
| ratio_wr | input | 1 | Ratio write strobe |
| ratio_wdata | input | RATIO_W | Ratio value to write |
| core_rst_n | output | 1 | Internal core reset, active low |
| ref_div2 | output | 1 | Reference clock divided by two |
| clk_sel_pll | output | 1 | 1 selects the PLL clock, 0 the halved reference |
| prog_mode | output | 1 | High in programming state, including a deferred exit |
| wr_open | output | 1 | Ratio writes may be taken |
| ratio | output | RATIO_W | Current clock ratio in tenths |
| bad_entry | output | 1 | Sticky: entry attempted without bypass |
| early_exit | output | 1 | Sticky: exit requested inside the settle window |

## Verification
The release of the reset is swept edge by edge. This separates the 8-edge internal reset, the divider phase and the 22-edge write window, so an off-by-one in any of the three is caught. The exit request is swept over offsets before, at and after the settle boundary. This tells a premature exit that is correctly deferred from a clean one, and shows that the early flag is sticky. The six reserved codes, entry without bypass, writes in run state and writes before the window opens are each applied alone. In each case the bench confirms that `ratio` and `prog_mode` do not move. Lock withheld on the return to the PLL shows the reset being stretched. A final external reset shows the default ratio coming back.

// File: rtl/cms_pkg.sv
// Shared types and mode codes for the reset and clock mode sequencer.
// Assumes mode pins are already synchronised to the reference clock.
package cms_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_PROG   = 2'd1,
        ST_DRAIN  = 2'd2
    } cms_state_e;

    localparam logic [2:0] MODE_RUN = 3'b000;
    localparam logic [2:0] MODE_PRG = 3'b111;
endpackage

// File: rtl/cms_downcnt.sv
// Down counter with a parameter-picked reset value, a reload input and a
// stall that can hold the count at one. done is high when the count is zero.
// Assumes SPAN >= 1.
module cms_downcnt #(
    parameter int unsigned SPAN       = 8,
    parameter bit          START_FULL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic stall,
    output logic done
);
    localparam int CW = $clog2(SPAN + 1);
    localparam logic [CW-1:0] FULL = CW'(SPAN);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] rst_val;

    generate
        if (START_FULL) begin : g_full
            assign rst_val = FULL;
        end else begin : g_empty
            assign rst_val = '0;
        end
    endgenerate

    // Count down to zero, reload on request, optionally hold at one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= rst_val;
        else if (load)
            cnt_q <= FULL;
        else if (cnt_q != '0 && !(stall && cnt_q == CW'(1)))
            cnt_q <= cnt_q - CW'(1);
    end

    assign done = (cnt_q == '0);

    p_no_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(!done) && done) |-> $past(cnt_q == CW'(1)));
endmodule

// File: rtl/cms_fsm.sv
// Mode state machine: decodes the mode pins, guards entry with the bypass
// pin, defers an early exit until the settle window ends and keeps the two
// sticky error flags. Assumes settle_done comes from a counter that a ratio
// write reloads.
module cms_fsm
    import cms_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel,
    input  logic       pll_bypass,
    input  logic       settle_done,
    output cms_state_e state,
    output logic       go_in,
    output logic       go_out,
    output logic       bad_entry,
    output logic       early_exit
);
    cms_state_e st_q, st_d;
    logic bad_set, early_set;

    // Next state and event decode.
    always_comb begin
        st_d      = st_q;
        go_in     = 1'b0;
        go_out    = 1'b0;
        bad_set   = 1'b0;
        early_set = 1'b0;
        case (st_q)
            ST_NORMAL: begin
                if (mode_sel == MODE_PRG) begin
                    if (pll_bypass) begin
                        st_d  = ST_PROG;
                        go_in = 1'b1;
                    end else begin
                        bad_set = 1'b1;
                    end
                end
            end
            ST_PROG: begin
                if (mode_sel == MODE_RUN) begin
                    if (settle_done) begin
                        st_d   = ST_NORMAL;
                        go_out = 1'b1;
                    end else begin
                        st_d      = ST_DRAIN;
                        early_set = 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (settle_done) begin
                    st_d   = ST_NORMAL;
                    go_out = 1'b1;
                end
            end
            default: st_d = ST_NORMAL;
        endcase
    end

    // State register and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_NORMAL;
            bad_entry  <= 1'b0;
            early_exit <= 1'b0;
        end else begin
            st_q <= st_d;
            if (bad_set)   bad_entry  <= 1'b1;
            if (early_set) early_exit <= 1'b1;
        end
    end

    assign state = st_q;

    p_exit_settled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_NORMAL && $past(st_q) != ST_NORMAL) |-> $past(settle_done));
    p_entry_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PROG && $past(st_q) == ST_NORMAL) |-> $past(pll_bypass));
endmodule

// File: rtl/clkmode_seq.sv
// Reset and clock mode sequencer top. Builds the internal reset pulse, the
// write-window and settle timers, the ratio register, the divide-by-two
// output and the clock select. Assumes all inputs are synchronous to clk,
// which is the reference clock; the clock mux itself is external.
module clkmode_seq
    import cms_pkg::*;
#(
    parameter int unsigned RATIO_W     = 8,
    parameter int unsigned RATIO_DEF   = 22,
    parameter int unsigned INT_RST_CYC = 8,
    parameter int unsigned ACCEPT_CYC  = 22,
    parameter int unsigned SETTLE_CYC  = 20000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         mode_sel,
    input  logic               pll_bypass,
    input  logic               pll_lock,
    input  logic               ratio_wr,
    input  logic [RATIO_W-1:0] ratio_wdata,
    output logic               core_rst_n,
    output logic               ref_div2,
    output logic               clk_sel_pll,
    output logic               prog_mode,
    output logic               wr_open,
    output logic [RATIO_W-1:0] ratio,
    output logic               bad_entry,
    output logic               early_exit
);
    localparam logic [RATIO_W-1:0] RATIO_RST = RATIO_W'(RATIO_DEF);

    cms_state_e state;
    logic go_in, go_out, settle_done, wr_take, need_lock;

    cms_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .pll_bypass (pll_bypass),
        .settle_done(settle_done),
        .state      (state),
        .go_in      (go_in),
        .go_out     (go_out),
        .bad_entry  (bad_entry),
        .early_exit (early_exit)
    );

    cms_downcnt #(.SPAN(ACCEPT_CYC), .START_FULL(1'b1)) u_accept (
        .clk(clk), .rst_n(rst_n), .load(1'b0), .stall(1'b0), .done(wr_open)
    );

    cms_downcnt #(.SPAN(SETTLE_CYC), .START_FULL(1'b0)) u_settle (
        .clk(clk), .rst_n(rst_n), .load(wr_take), .stall(1'b0), .done(settle_done)
    );

    cms_downcnt #(.SPAN(INT_RST_CYC), .START_FULL(1'b1)) u_pulse (
        .clk(clk), .rst_n(rst_n), .load(go_in | go_out),
        .stall(need_lock & ~pll_lock), .done(core_rst_n)
    );

    assign need_lock = (state == ST_NORMAL);
    assign wr_take   = ratio_wr && wr_open && (state == ST_PROG);
    assign prog_mode = (state != ST_NORMAL);

    // Ratio register: default on external reset only.
    always_ff @(posedge clk) begin
        if (!rst_n)       ratio <= RATIO_RST;
        else if (wr_take) ratio <= ratio_wdata;
    end

    // Divide-by-two phase, cleared by the external reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_div2 <= 1'b0;
        else        ref_div2 <= ~ref_div2;
    end

    // Clock select follows the state only while the core is in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           clk_sel_pll <= 1'b1;
        else if (!core_rst_n) clk_sel_pll <= (state == ST_NORMAL);
    end

    p_sel_in_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel_pll != $past(clk_sel_pll)) |-> !$past(core_rst_n));
    p_mode_resets_core_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_mode != $past(prog_mode)) |-> !core_rst_n);
    p_ratio_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio != $past(ratio)) |-> $past(ratio_wr && prog_mode && wr_open));
    p_lock_before_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> $past(pll_lock || prog_mode));
    p_open_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_open |=> wr_open);
endmodule

// File: tb/clkmode_seq_tb.sv
module clkmode_seq_tb;
    localparam int S = 12;
    localparam int P = 8;
    localparam int A = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic pll_bypass = 1'b0, pll_lock = 1'b1, ratio_wr = 1'b0;
    logic [7:0] ratio_wdata = '0;
    logic core_rst_n, ref_div2, clk_sel_pll, prog_mode, wr_open, bad_entry, early_exit;
    logic [7:0] ratio;
    int vectors = 0, misses = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    clkmode_seq #(.SETTLE_CYC(S)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pll_bypass(pll_bypass),
        .pll_lock(pll_lock), .ratio_wr(ratio_wr), .ratio_wdata(ratio_wdata),
        .core_rst_n(core_rst_n), .ref_div2(ref_div2), .clk_sel_pll(clk_sel_pll),
        .prog_mode(prog_mode), .wr_open(wr_open), .ratio(ratio),
        .bad_entry(bad_entry), .early_exit(early_exit)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_ratio(input logic [7:0] v);
        ratio_wdata = v;
        ratio_wr = 1'b1;
        step(1);
        ratio_wr = 1'b0;
    endtask

    task automatic enter_prog();
        mode_sel = 3'b111;
        pll_bypass = 1'b1;
        step(1);
        chk("R1 entry", prog_mode, 1);
        chk("R9 entry reset", core_rst_n, 0);
        step(1);
        chk("R10 sel to ref", clk_sel_pll, 0);
        step(P - 1);
        chk("R9 entry pulse end", core_rst_n, 1);
    endtask

    initial begin
        int exit_at;
        bit any_early;
        int offs[5] = '{13, 16, 5, 1, 12};
        step(3);
        chk("R2 core", core_rst_n, 0);
        chk("R2 prog", prog_mode, 0);
        chk("R2 ratio", ratio, 22);
        chk("R2 sel", clk_sel_pll, 1);
        chk("R2 div", ref_div2, 0);
        chk("R2 open", wr_open, 0);
        chk("R2 flags", {bad_entry, early_exit}, 0);

        rst_n = 1'b1;
        for (int k = 1; k <= 30; k++) begin
            step(1);
            chk($sformatf("R3 k=%0d", k), core_rst_n, (k >= P) ? 1 : 0);
            chk($sformatf("R4 k=%0d", k), ref_div2, k % 2);
            chk($sformatf("R5 k=%0d", k), wr_open, (k >= A) ? 1 : 0);
        end

        for (int c = 1; c <= 6; c++) begin
            mode_sel = 3'(c);
            pll_bypass = 1'b1;
            step(1);
            chk($sformatf("R1 reserved %0d", c), prog_mode, 0);
            chk("R1 reserved flag", bad_entry, 0);
        end

        mode_sel = 3'b111;
        pll_bypass = 1'b0;
        step(2);
        chk("R7 no entry", prog_mode, 0);
        chk("R7 flag", bad_entry, 1);
        mode_sel = 3'b000;
        step(1);

        write_ratio(8'd55);
        chk("R6 ignored in run", ratio, 22);

        enter_prog();
        any_early = 1'b0;
        foreach (offs[i]) begin
            int k = offs[i];
            int v = 30 + k;
            write_ratio(8'(v));
            chk("R6 write taken", ratio, v);
            exit_at = 0;
            for (int e = 1; e <= 40; e++) begin
                if (e == k) mode_sel = 3'b000;
                step(1);
                if (!prog_mode) begin
                    exit_at = e;
                    break;
                end
            end
            if (k <= S) any_early = 1'b1;
            chk($sformatf("R8 exit edge k=%0d", k), exit_at, (k > S + 1) ? k : S + 1);
            chk($sformatf("R8 early flag k=%0d", k), early_exit, any_early);
            chk("R9 exit reset", core_rst_n, 0);
            chk("R9 ratio kept", ratio, v);
            step(1);
            chk("R10 sel to pll", clk_sel_pll, 1);
            step(P - 1);
            chk("R9 exit pulse end", core_rst_n, 1);
            enter_prog();
        end

        write_ratio(8'd77);
        step(S + 1);
        pll_lock = 1'b0;
        mode_sel = 3'b000;
        step(1);
        chk("R11 exited", prog_mode, 0);
        step(20);
        chk("R11 held", core_rst_n, 0);
        pll_lock = 1'b1;
        step(1);
        chk("R11 released", core_rst_n, 1);

        rst_n = 1'b0;
        step(2);
        chk("R9 default back", ratio, 22);
        chk("R2 flags cleared", {bad_entry, early_exit}, 0);
        rst_n = 1'b1;
        mode_sel = 3'b111;
        pll_bypass = 1'b1;
        step(3);
        write_ratio(8'd99);
        chk("R5 early write ignored", ratio, 22);
        step(A);
        write_ratio(8'd99);
        chk("R5 write after open", ratio, 99);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            vectors++;
            misses++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule